// File: doc/BRIEF.md
# Accumulator Three-Weight Pattern Generator

This block produces weighted pseudo-random test patterns for built-in self-test from an ordinary adder-based accumulator. Register A holds the current pattern and register B holds a constant addend. While the block runs, every clock adds B to A through one full-adder stage per bit. A short sequence of weight assignments, called sessions, is applied in turn. In each session every pattern bit is either pinned to 0, pinned to 1, or left free to take the accumulated value.

Pinning uses the asynchronous set and clear inputs of the cell flip-flops. The decoded force signals drive A one way and the B flip-flop at the same position the other way. Because a pinned stage then always holds one 1 and one 0, its carry-out equals its carry-in, and the free stages keep the arithmetic sequence they would have without the pinned stages. A start pulse begins a run. Each session lasts a programmed number of steps. After the last session the block raises done and freezes its pattern.

Top module: `acc3w_gen`

## Requirements
- R1: The weight table parameter holds two bits per input per session at offset (session*WIDTH+bit)*2. The upper bit is the force flag and the lower bit is the force value. While a session is active, every flagged pattern bit equals its force value, including during and straight after reset. With default parameters, session 0 pins bits 2 and 0 to 1, and session 1 pins bits 2 and 0 to 0 and bit 1 to 1.
- R2: On each running clock, the free bits of A take the sum A + B with carry-in 0. Every pinned stage passes its incoming carry unchanged to the next stage.
- R3: The B bits that are free in a session reload the seed parameter (default 5'b01011) on every clock. A bit that is pinned in one session and free in the next keeps its pinned A and B contents going into its first step.
- R4: After reset the free bits of A are 0, session_o is 0 and done_o is 0.
- R5: Before start, the pattern and session do not change.
- R6: The start_i pulse is taken only when the block is idle, and stepping begins on the clock after it. Each session lasts the sampled count of steps, and session_o then advances by one.
- R7: After the last step of the last session, done_o rises and stays high. From then on the pattern and session hold, and start_i has no effect until reset.
- R8: The pps_i value is sampled with start. Later changes to it have no effect, and a sampled value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| pps_i | input | CNT_W | Steps per session |
| pattern_o | output | WIDTH | Test pattern (register A) |
| session_o | output | SES_W | Active weight assignment |
| done_o | output | 1 | All sessions complete |

## Verification
A wrong force decode shows on the very next sample as a pinned pattern bit that holds the wrong level. A broken carry pass-through, or a wrong B level in a pinned stage, leaves the pinned bits correct. It corrupts the free bits above that stage, and this shows within one step. A fault in the session or step counters shows only at session boundaries, either as session_o moving one step early or late or as done_o appearing after the wrong number of steps. The bench therefore counts the steps to done for several step counts, including 0 and 1.

// File: rtl/acc3w_pkg.sv
package acc3w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/acc3w_cell.sv
// Flip-flop with asynchronous set/clear taking priority over reset.
module acc3w_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge set_i or posedge clr_i or negedge rst_ni) begin
    if (set_i)        q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
    else if (!rst_ni) q_o <= RST_VAL;
    else              q_o <= d_i;
  end
endmodule

// File: rtl/acc3w_decode.sv
module acc3w_decode #(
  parameter int WIDTH    = 5,
  parameter int SESSIONS = 2,
  parameter int SES_W    = 1,
  parameter logic [2*WIDTH*SESSIONS-1:0] WEIGHT_TBL = '0
) (
  input  logic [SES_W-1:0] session_i,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o
);
  always_comb begin
    set_o = '0;
    clr_o = '0;
    for (int s = 0; s < SESSIONS; s++) begin
      if (session_i == SES_W'(s)) begin
        for (int i = 0; i < WIDTH; i++) begin
          if (WEIGHT_TBL[(s*WIDTH+i)*2+1]) begin
            set_o[i] = WEIGHT_TBL[(s*WIDTH+i)*2];
            clr_o[i] = !WEIGHT_TBL[(s*WIDTH+i)*2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/acc3w_seq.sv
module acc3w_seq
  import acc3w_pkg::*;
#(
  parameter int SESSIONS = 2,
  parameter int SES_W    = 1,
  parameter int CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pps_i,
  output logic             run_o,
  output logic [SES_W-1:0] session_o,
  output logic             done_o
);
  localparam logic [SES_W-1:0] LAST_SES = SES_W'(SESSIONS - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pps_q;
  logic [SES_W-1:0] ses_q;
  logic             last_step;

  assign last_step = (cnt_q == pps_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pps_q   <= CNT_W'(1);
      ses_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          pps_q   <= (pps_i == '0) ? CNT_W'(1) : pps_i;
        end
        ST_RUN: begin
          if (last_step) begin
            cnt_q <= '0;
            if (ses_q == LAST_SES) state_q <= ST_DONE;
            else                   ses_q   <= ses_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign done_o    = (state_q == ST_DONE);
  assign session_o = ses_q;
endmodule

// File: rtl/acc3w_gen.sv
module acc3w_gen #(
  parameter int WIDTH    = 5,
  parameter int SESSIONS = 2,
  parameter int CNT_W    = 16,
  parameter logic [WIDTH-1:0] SEED = 5'b01011,
  parameter logic [2*WIDTH*SESSIONS-1:0] WEIGHT_TBL =
    {10'b00_00_10_11_10, 10'b00_00_11_00_11}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     pps_i,
  output logic [WIDTH-1:0]     pattern_o,
  output logic [((SESSIONS > 1) ? $clog2(SESSIONS) : 1)-1:0] session_o,
  output logic                 done_o
);
  localparam int SES_W = (SESSIONS > 1) ? $clog2(SESSIONS) : 1;

  logic             run;
  logic [WIDTH-1:0] a_set, a_clr;
  logic [WIDTH-1:0] a_q, b_q, sum;
  logic [WIDTH:0]   carry;

  acc3w_seq #(.SESSIONS(SESSIONS), .SES_W(SES_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .pps_i,
    .run_o(run), .session_o(session_o), .done_o(done_o)
  );

  acc3w_decode #(.WIDTH(WIDTH), .SESSIONS(SESSIONS), .SES_W(SES_W),
                 .WEIGHT_TBL(WEIGHT_TBL)) u_dec (
    .session_i(session_o), .set_o(a_set), .clr_o(a_clr)
  );

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = a_q[i] ^ b_q[i] ^ carry[i];
    assign carry[i+1] = (a_q[i] & b_q[i]) | (carry[i] & (a_q[i] ^ b_q[i]));

    acc3w_cell #(.RST_VAL(1'b0)) u_a (
      .clk_i, .rst_ni, .set_i(a_set[i]), .clr_i(a_clr[i]),
      .d_i(run ? sum[i] : a_q[i]), .q_o(a_q[i])
    );
    // B is pinned opposite to A so the stage passes its carry
    acc3w_cell #(.RST_VAL(SEED[i])) u_b (
      .clk_i, .rst_ni, .set_i(a_clr[i]), .clr_i(a_set[i]),
      .d_i(SEED[i]), .q_o(b_q[i])
    );
  end

  assign pattern_o = a_q;
endmodule

// File: rtl/acc3w_gen_chk.sv
module acc3w_gen_chk #(
  parameter int WIDTH    = 5,
  parameter int SESSIONS = 2,
  parameter int SES_W    = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             done_o,
  input logic [SES_W-1:0] session_o,
  input logic [WIDTH-1:0] pattern_o,
  input logic [WIDTH-1:0] b_q,
  input logic [WIDTH-1:0] a_set,
  input logic [WIDTH-1:0] a_clr,
  input logic [WIDTH:0]   carry
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // R1
    forced_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_set[i] |-> (pattern_o[i] && !b_q[i]));
    // R1
    forced_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_clr[i] |-> (!pattern_o[i] && b_q[i]));
    // R2
    carry_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_set[i] || a_clr[i]) |-> (carry[i+1] == carry[i]));
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !done_o) |=> ($stable(pattern_o) || run));
  // R6
  ses_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(session_o));
  // R6
  ses_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    session_o <= SES_W'(SESSIONS - 1));
  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(pattern_o) && $stable(session_o)));
endmodule

bind acc3w_gen acc3w_gen_chk #(.WIDTH(WIDTH), .SESSIONS(SESSIONS), .SES_W(SES_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .done_o(done_o),
  .session_o(session_o), .pattern_o(pattern_o), .b_q(b_q),
  .a_set(a_set), .a_clr(a_clr), .carry(carry)
);

// File: tb/acc3w_gen_tb_top.sv
`timescale 1ns/1ps
module acc3w_gen_tb_top;
  localparam logic [4:0] SEED = 5'b01011;
  localparam logic [4:0] FM [2] = '{5'b00101, 5'b00111};
  localparam logic [4:0] FV [2] = '{5'b00101, 5'b00010};
  localparam int NSCN = 5;
  localparam logic [15:0] SCN_PPS  [NSCN] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd7};
  localparam int          SCN_STEP [NSCN] = '{2, 2, 4, 6, 14};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pps_i = '0;
  logic [4:0]  pattern_o;
  logic        session_o;
  logic        done_o;

  int n_chk = 0;
  int n_err = 0;

  logic [4:0] ma, mb;
  int ms, mcnt, mpps;
  bit mrun, mdone;

  always #10 clk_i = ~clk_i;

  acc3w_gen dut_i (
    .clk_i, .rst_ni, .start_i, .pps_i, .pattern_o, .session_o, .done_o
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pin_model();
    ma = (ma & ~FM[ms]) | (FV[ms] & FM[ms]);
    mb = (mb & ~FM[ms]) | (~FV[ms] & FM[ms]);
  endtask

  task automatic model_edge();
    logic [4:0] na, nb;
    logic c;
    na = ma;
    c  = 1'b0;
    for (int i = 0; i < 5; i++) begin
      nb[i] = FM[ms][i] ? mb[i] : SEED[i];
      if (mrun && !FM[ms][i]) begin
        na[i] = ma[i] ^ mb[i] ^ c;
        c = (ma[i] & mb[i]) | (c & (ma[i] ^ mb[i]));
      end
    end
    if (mrun) begin
      if (mcnt == mpps - 1) begin
        mcnt = 0;
        if (ms == 1) begin mrun = 0; mdone = 1; end
        else ms++;
      end else mcnt++;
    end else if (!mdone && start_i) begin
      mrun = 1;
      mcnt = 0;
      mpps = (pps_i == 0) ? 1 : int'(pps_i);
    end
    ma = na;
    mb = nb;
    pin_model();
  endtask

  task automatic compare();
    chk("R1", "pinned bits", 32'(pattern_o & FM[ms]), 32'(FV[ms] & FM[ms]));
    chk("R2 R3", "free bits", 32'(pattern_o & ~FM[ms]), 32'(ma & ~FM[ms]));
    chk("R6", "session", 32'(session_o), 32'(ms));
    chk("R7", "done", 32'(done_o), 32'(mdone));
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    start_i = 1'b0;
    ms = 0; mcnt = 0; mpps = 1; mrun = 0; mdone = 0;
    ma = 5'b0;
    mb = SEED;
    pin_model();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSCN; k++) begin
      int steps;
      do_reset();
      // R4: reset state
      chk("R4", "reset pattern", 32'(pattern_o), 32'(5'b00101));
      chk("R4", "reset session", 32'(session_o), 32'd0);
      chk("R4", "reset done", 32'(done_o), 32'd0);
      // R5: idle hold
      repeat (3) cyc();
      chk("R5", "idle pattern", 32'(pattern_o), 32'(5'b00101));
      pps_i   = SCN_PPS[k];
      start_i = 1'b1;
      cyc();
      start_i = 1'b0;
      pps_i   = 16'd9; // R8: later change ignored
      steps = 0;
      while (!done_o && steps < 100) begin
        start_i = (k == 3 && steps == 1); // R6: start ignored while running
        cyc();
        steps++;
      end
      start_i = 1'b0;
      chk("R6 R8", "steps to done", 32'(steps), 32'(SCN_STEP[k]));
      begin
        logic [4:0] held;
        held = pattern_o;
        // R7: start after done has no effect
        start_i = 1'b1;
        repeat (3) cyc();
        start_i = 1'b0;
        cyc();
        chk("R7", "pattern held", 32'(pattern_o), 32'(held));
        chk("R7", "done held", 32'(done_o), 32'd1);
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule